// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a memory-mapped periodic tick source for an operating-system scheduler. A 24-bit down-counter is loaded from a software-written reload register. When it reaches zero, it restarts from the reload value on its own. Each time the count passes from one to zero, the block sets a sticky wrap flag. If interrupts are enabled, it also pulses an interrupt request for one cycle.

Software reaches three registers through a small single-cycle read/write port. A control/status word holds the enable, interrupt-enable and tick-source bits plus the wrap flag. The reload value and the live count are the other two registers. The counter advances either on every core clock or on a slower reference strobe supplied from outside, chosen by one control bit.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Reload (offset 0x014) and current count (offset 0x018) hold 24 bits; bits 31:24 read as zero and written values there are ignored.
- R3: With run (control bit 0) and core source (control bit 2) set and reload N>0, the counter reloads from zero on its next tick, then steps down by one per cycle, so a 1-to-0 pass recurs every N+1 cycles without software action.
- R4: `irq` is a one-cycle pulse, high in the cycle the count has just gone from 1 to 0, and only when run and interrupt-enable (control bit 1) are both set.
- R5: Control bit 16 is set by every 1-to-0 pass, whether or not interrupt-enable is set; a read of the control register returns it and clears it, and a pass on the same cycle as the read wins.
- R6: With control bit 2 clear, the counter advances only in cycles where `ref_tick` is high.
- R7: With run clear the count holds its value.
- R8: Any write to the current-count register sets the count to zero and clears the wrap flag, with no `irq`.
- R9: A reload value of zero keeps the counter at zero; no flag and no `irq` result.
- R10: Read data appears on `bus_rdata` the cycle after the read request; control bits other than 0, 1, 2 and 16 read as zero and ignore writes, and offsets other than 0x010, 0x014 and 0x018 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the system control region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| ref_tick | input | 1 | Slow reference strobe, one clock wide, synchronous to clk |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A write takes effect at the clock edge that samples it. Read data is due one edge after the read is sampled. The counter loads or steps at the first edge after a write that enables it, and `irq` rises at the same edge that takes the count from 1 to 0. Each task drives at falling edges and samples one falling edge after each rising edge. Expected counts follow from that edge arithmetic: for example, reload 4 gives pulses after edges 5, 10, 15 and 20 following the enabling write.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 12'h018;

    localparam int unsigned BIT_RUN   = 0;
    localparam int unsigned BIT_IRQEN = 1;
    localparam int unsigned BIT_CORE  = 2;
    localparam int unsigned BIT_WRAP  = 16;

    typedef struct packed {
        logic core_src;
        logic irq_en;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LOAD,
        SEL_COUNT
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        case (ofs)
            OFS_CTRL:  return SEL_CTRL;
            OFS_LOAD:  return SEL_LOAD;
            OFS_COUNT: return SEL_COUNT;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run      = w[BIT_RUN];
        c.irq_en   = w[BIT_IRQEN];
        c.core_src = w[BIT_CORE];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c, input logic wrap);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[BIT_RUN]   = c.run;
        w[BIT_IRQEN] = c.irq_en;
        w[BIT_CORE]  = c.core_src;
        w[BIT_WRAP]  = wrap;
        return w;
    endfunction

endpackage

// File: rtl/tick_timer_src.sv
module tick_timer_src #(
    parameter bit REF_IS_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic core_src,
    input  logic ref_tick,
    output logic tick
);
    logic ref_evt;

    generate
        if (REF_IS_LEVEL) begin : g_edge
            logic ref_d;
            always_ff @(posedge clk) begin
                if (rst) ref_d <= 1'b0;
                else     ref_d <= ref_tick;
            end
            assign ref_evt = ref_tick & ~ref_d;
        end else begin : g_strobe
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign ref_evt = ref_tick;
        end
    endgenerate

    assign tick = core_src ? 1'b1 : ref_evt;

endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    assign step = tick & run & ~clr;
    assign hit  = step & (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (step) begin
            if (count == '0) count <= reload;
            else             count <= count - ONE;
        end
    end

endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              hit,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              clr,
    output logic              wrap_flag,
    output logic              irq
);
    reg_sel_e sel;
    logic     wr_en;
    logic     rd_en;
    logic [DATA_W-1:0] rd_val;

    assign sel   = decode_ofs(bus_addr);
    assign wr_en = bus_req & bus_wr;
    assign rd_en = bus_req & ~bus_wr;
    assign clr   = wr_en & (sel == SEL_COUNT);

    always_comb begin
        case (sel)
            SEL_CTRL:  rd_val = pack_ctrl(ctrl, wrap_flag);
            SEL_LOAD:  rd_val = DATA_W'(reload);
            SEL_COUNT: rd_val = DATA_W'(count);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            reload    <= '0;
            wrap_flag <= 1'b0;
            irq       <= 1'b0;
            bus_rdata <= '0;
        end else begin
            irq       <= hit & ctrl.irq_en;
            bus_rdata <= rd_en ? rd_val : '0;
            if (wr_en && sel == SEL_CTRL) ctrl   <= unpack_ctrl(bus_wdata);
            if (wr_en && sel == SEL_LOAD) reload <= bus_wdata[CNT_W-1:0];
            if (hit)
                wrap_flag <= 1'b1;
            else if (clr || (rd_en && sel == SEL_CTRL))
                wrap_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W        = 24,
    parameter bit          REF_IS_LEVEL = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ref_tick,
    output logic        irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             hit;
    logic             clr;
    logic             wrap_flag;

    tick_timer_src #(.REF_IS_LEVEL(REF_IS_LEVEL)) u_src (
        .clk      (clk),
        .rst      (rst),
        .core_src (ctrl.core_src),
        .ref_tick (ref_tick),
        .tick     (tick)
    );

    tick_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run    (ctrl.run),
        .clr    (clr),
        .reload (reload),
        .count  (count),
        .hit    (hit)
    );

    tick_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count),
        .hit       (hit),
        .ctrl      (ctrl),
        .reload    (reload),
        .clr       (clr),
        .wrap_flag (wrap_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_req,
    input logic             bus_wr,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             irq,
    input ctrl_t            ctrl,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             clr,
    input logic             wrap_flag
);
    localparam logic [31:0] HI_MASK = ~((32'd1 << CNT_W) - 32'd1);

    p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_enables_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ctrl.run && ctrl.irq_en));

    p_irq_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (count == '0));

    p_irq_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> wrap_flag);

    p_hold_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !clr) |=> $stable(count));

    p_clear_no_irq_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0) && !wrap_flag && !irq);

    p_zero_reload_r9: assert property (@(posedge clk) disable iff (rst)
        (reload == '0 && count == '0) |=> (count == '0));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_wr && (bus_addr == OFS_LOAD || bus_addr == OFS_COUNT))
        |=> ((bus_rdata & HI_MASK) == 32'd0));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ctrl      (ctrl),
    .count     (count),
    .reload    (reload),
    .clr       (clr),
    .wrap_flag (wrap_flag)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [11:0] A_CTRL  = 12'h010;
    localparam logic [11:0] A_LOAD  = 12'h014;
    localparam logic [11:0] A_COUNT = 12'h018;

    always #2.5 clk = ~clk;

    tick_timer i_tick_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_tick  (ref_tick),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic run_cycles(input int n, output int pulses, output int doubles);
        bit prev = 1'b0;
        pulses = 0; doubles = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq) pulses++;
            if (irq && prev) doubles++;
            prev = irq;
        end
    endtask

    task automatic quiesce(input logic [31:0] load);
        logic [31:0] d;
        bus_write(A_CTRL, 32'h0);
        bus_write(A_LOAD, load);
        bus_write(A_COUNT, 32'h0);
        bus_read(A_CTRL, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        bus_read(A_CTRL, d);  check("R1 control after reset", d, 32'h0);
        bus_read(A_LOAD, d);  check("R1 reload after reset", d, 32'h0);
        bus_read(A_COUNT, d); check("R1 count after reset", d, 32'h0);
    endtask

    task automatic t_widths;
        logic [31:0] d;
        bus_write(A_LOAD, 32'hFFFF_FFFF);
        bus_read(A_LOAD, d);  check("R2 reload upper bits", d, 32'h00FF_FFFF);
        bus_write(A_CTRL, 32'hFFFF_FFF8);
        bus_read(A_CTRL, d);  check("R10 control spare bits", d, 32'h0);
        bus_read(12'h01C, d); check("R10 unmapped 0x01C", d, 32'h0);
        bus_read(12'h000, d); check("R10 unmapped 0x000", d, 32'h0);
    endtask

    task automatic t_core_period;
        logic [31:0] d;
        int p, dbl;
        quiesce(32'd4);
        bus_write(A_CTRL, 32'h7);
        run_cycles(20, p, dbl);
        check("R3 pulses in 20 cycles, reload 4", p, 4);
        check("R4 irq one cycle wide", dbl, 0);
        bus_read(A_CTRL, d);  check("R5 flag read", d, 32'h0001_0007);
        bus_read(A_CTRL, d);  check("R5 flag cleared by read", d, 32'h0000_0007);
    endtask

    task automatic t_no_irq_en;
        logic [31:0] d;
        int p, dbl;
        quiesce(32'd2);
        bus_write(A_CTRL, 32'h5);
        run_cycles(12, p, dbl);
        check("R4 no irq with irq_en clear", p, 0);
        bus_read(A_CTRL, d);  check("R5 flag without irq_en", d, 32'h0001_0005);
    endtask

    task automatic t_hold;
        logic [31:0] d;
        int p, dbl;
        quiesce(32'd50);
        bus_write(A_CTRL, 32'h7);
        run_cycles(7, p, dbl);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_COUNT, d); check("R7 count when stopped", d, 32'd43);
        run_cycles(5, p, dbl);
        bus_read(A_COUNT, d); check("R7 count still held", d, 32'd43);
        check("R7 no irq while stopped", p, 0);
    endtask

    task automatic t_ref_source;
        logic [31:0] d;
        int p, dbl, pulses;
        quiesce(32'd3);
        bus_write(A_CTRL, 32'h3);
        run_cycles(10, p, dbl);
        bus_read(A_COUNT, d); check("R6 idle without ref_tick", d, 32'h0);
        pulses = p;
        for (int i = 0; i < 4; i++) begin
            ref_tick = 1'b1;
            @(posedge clk); @(negedge clk);
            ref_tick = 1'b0;
            if (irq) pulses++;
            run_cycles(2, p, dbl);
            pulses += p;
        end
        check("R6 one irq after four ref ticks", pulses, 1);
        bus_read(A_COUNT, d); check("R6 count at zero", d, 32'h0);
        ref_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        ref_tick = 1'b0;
        bus_read(A_COUNT, d); check("R6 reload on next ref tick", d, 32'd3);
    endtask

    task automatic t_zero_reload;
        logic [31:0] d;
        int p, dbl;
        quiesce(32'd0);
        bus_write(A_CTRL, 32'h7);
        run_cycles(20, p, dbl);
        check("R9 no irq with reload 0", p, 0);
        bus_read(A_COUNT, d); check("R9 count stays 0", d, 32'h0);
        bus_read(A_CTRL, d);  check("R9 no flag", d, 32'h7);
    endtask

    task automatic t_count_write;
        logic [31:0] d;
        int p, dbl;
        quiesce(32'd2);
        bus_write(A_CTRL, 32'h7);
        run_cycles(10, p, dbl);
        bus_write(A_CTRL, 32'h0);
        bus_write(A_COUNT, 32'h123);
        check("R8 no irq on count write", {31'b0, irq}, 32'h0);
        bus_read(A_CTRL, d);  check("R8 flag cleared by count write", d, 32'h0);
        bus_read(A_COUNT, d); check("R8 count cleared", d, 32'h0);
    endtask

    initial begin
        #(5ns * 50000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_widths();
        t_core_period();
        t_no_irq_en();
        t_hold();
        t_ref_source();
        t_zero_reload();
        t_count_write();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule